// File: doc/BRIEF.md
# Partitioned byte-by-halfword SIMD multiplier

This unit multiplies packed 8-bit values by packed signed 16-bit values held in two 64-bit operands. It produces one 64-bit result per accepted operation. A 3-bit operation code selects how the 8-bit operands are picked from `src_a`, which 16-bit lane of `src_b` serves as the multiplier, and whether the result is packed as four 16-bit lanes or two 32-bit words.

Each lane forms a 32-bit signed product. A rounding increment is added when the low byte of that product has its top bit set. The narrow forms return bits [23:8] of the rounded product. The wide forms return the whole rounded product for the two lowest lanes. Operands are presented with `in_valid`. The result and `out_valid` are registered and appear one clock later. The result register keeps its value while no operation is accepted.

Top module: `pmul_8x16`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R2: Reset drives `out_valid` and `result` to zero. While `in_valid` is low, `result` keeps its last value whatever `op`, `src_a` and `src_b` carry.
- R3: Opcode 0: result lane r (bits [16r+15:16r], r = 0..3) is formed from the unsigned byte `src_a[8r+7:8r]` times the signed lane `src_b[16r+15:16r]`.
- R4: Each lane product is a 32-bit signed value. If its bits [7:0] are 0x80 or above, 0x100 is added. A 16-bit lane result is bits [23:8] of the sum, and higher bits are discarded.
- R5: Opcode 1: as opcode 0, but every lane uses `src_b[31:16]` as its multiplier.
- R6: Opcode 2: as opcode 0, but every lane uses `src_b[15:0]` as its multiplier.
- R7: Opcode 3: lane r multiplies the signed byte `src_a[16r+15:16r+8]` by the signed lane `src_b[16r+15:16r]`.
- R8: Opcode 4: lane r multiplies the unsigned byte `src_a[16r+7:16r]` by the signed lane `src_b[16r+15:16r]`.
- R9: Opcodes 5 and 6 pick operands as opcodes 3 and 4 respectively, for lanes 0 and 1 only. They apply the same rounding increment and place lane r's full 32-bit sum in `result[32r+31:32r]`.
- R10: Opcode 7 yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and opcode are accepted this cycle |
| op | input | 3 | Operation select, codes 0 to 7 |
| src_a | input | 64 | Packed 8-bit operand source |
| src_b | input | 64 | Packed signed 16-bit multiplier source |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered packed result |

## Verification
Every result is due at the first rising edge after the falling edge at which its operands are driven. `out_valid` and `result` both change at that edge. The driver pushes the expected value into a queue when it applies the operands. The monitor samples two nanoseconds after each rising edge and pops one entry for every cycle in which `out_valid` is high. In idle cycles it checks that `result` equals the last value popped, while the driver puts random data on the operand inputs.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [2:0] {
    OP_LANE  = 3'd0,  // per-lane byte x halfword
    OP_BC_LO = 3'd1,  // multiplier taken from halfword 1 for all lanes
    OP_BC_HI = 3'd2,  // multiplier taken from halfword 0 for all lanes
    OP_SHI   = 3'd3,  // signed high byte of each halfword
    OP_ULO   = 3'd4,  // unsigned low byte of each halfword
    OP_WSHI  = 3'd5,  // wide form of OP_SHI, lanes 0 and 1
    OP_WULO  = 3'd6,  // wide form of OP_ULO, lanes 0 and 1
    OP_NONE  = 3'd7   // reserved: zero result
  } pmul_op_e;

endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  pmul_op_e                   op,
  input  logic [LANE_W/2-1:0]        byte_lo,
  input  logic [LANE_W-1:0]          a_lane,
  input  logic [LANE_W-1:0]          b_own,
  input  logic [LANE_W-1:0]          b_lane0,
  input  logic [LANE_W-1:0]          b_lane1,
  output logic signed [LANE_W/2:0]   mcand,
  output logic signed [LANE_W-1:0]   mplier
);

  localparam int BYTE_W = LANE_W / 2;

  always_comb begin
    mcand  = {1'b0, byte_lo};
    mplier = b_own;
    case (op)
      OP_BC_LO: mplier = b_lane1;
      OP_BC_HI: mplier = b_lane0;
      OP_SHI, OP_WSHI: mcand = {a_lane[LANE_W-1], a_lane[LANE_W-1 -: BYTE_W]};
      OP_ULO, OP_WULO: mcand = {1'b0, a_lane[BYTE_W-1:0]};
      default: ;
    endcase
  end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int LANE_W = 16
) (
  input  logic signed [LANE_W/2:0]   mcand,
  input  logic signed [LANE_W-1:0]   mplier,
  output logic [2*LANE_W-1:0]        rnd
);

  localparam int BYTE_W = LANE_W / 2;
  localparam int PROD_W = 2 * LANE_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;
  logic signed [PROD_W-1:0] raw;

  always_comb begin
    a_ext = {{(PROD_W-BYTE_W-1){mcand[BYTE_W]}}, mcand};
    b_ext = {{(PROD_W-LANE_W){mplier[LANE_W-1]}}, mplier};
    raw   = a_ext * b_ext;
    // round on the top bit of the low byte
    rnd   = raw + {{(PROD_W-BYTE_W-1){1'b0}}, raw[BYTE_W-1], {BYTE_W{1'b0}}};
  end

endmodule

// File: rtl/pmul_8x16.sv
module pmul_8x16
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                op,
  input  logic [LANES*LANE_W-1:0]   src_a,
  input  logic [LANES*LANE_W-1:0]   src_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   result
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int BYTE_W = LANE_W / 2;
  localparam int PROD_W = 2 * LANE_W;
  localparam int WIDE_N = LANES / 2;

  pmul_op_e op_e;
  assign op_e = pmul_op_e'(op);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [DATA_W-1:0] narrow_all;
  logic [DATA_W-1:0] wide_all;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [BYTE_W:0]   mcand;
    logic signed [LANE_W-1:0] mplier;
    logic [PROD_W-1:0]        rnd;

    pmul_opsel #(.LANE_W(LANE_W)) u_sel (
      .op      (op_e),
      .byte_lo (src_a[BYTE_W*j +: BYTE_W]),
      .a_lane  (src_a[LANE_W*j +: LANE_W]),
      .b_own   (src_b[LANE_W*j +: LANE_W]),
      .b_lane0 (src_b[0 +: LANE_W]),
      .b_lane1 (src_b[LANE_W +: LANE_W]),
      .mcand   (mcand),
      .mplier  (mplier)
    );

    pmul_lane #(.LANE_W(LANE_W)) u_mul (
      .mcand  (mcand),
      .mplier (mplier),
      .rnd    (rnd)
    );

    assign narrow_all[LANE_W*j +: LANE_W] = rnd[BYTE_W +: LANE_W];

    if (j < WIDE_N) begin : g_wide
      assign wide_all[PROD_W*j +: PROD_W] = rnd;
    end else begin : g_narrow_only
      logic unused_bits;
      assign unused_bits = ^{rnd[PROD_W-1:BYTE_W+LANE_W], rnd[BYTE_W-1:0]};
    end
  end

  // next-state
  logic              vld_d;
  logic [DATA_W-1:0] res_d;

  always_comb begin
    vld_d = in_valid;
    case (op_e)
      OP_NONE:          res_d = '0;
      OP_WSHI, OP_WULO: res_d = wide_all;
      default:          res_d = narrow_all;
    endcase
  end

  // registers
  logic              vld_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

endmodule

// File: rtl/pmul_8x16_chk.sv
module pmul_8x16_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              op,
  input logic [LANES*LANE_W-1:0] src_a,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] result
);

  localparam int BYTE_W = LANE_W / 2;
  localparam int LOW_W  = LANES * BYTE_W;

  logic bytes_same;
  assign bytes_same = (src_a[LOW_W-1:0] == {LANES{src_a[BYTE_W-1:0]}});

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_zero_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0 && src_a[LOW_W-1:0] == '0) |=> (result == '0));

  p_bcast_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1 && bytes_same) |=> (result == {LANES{result[LANE_W-1:0]}}));

  p_bcast_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2 && bytes_same) |=> (result == {LANES{result[LANE_W-1:0]}}));

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (result == '0));

endmodule

bind pmul_8x16 pmul_8x16_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .op        (op),
  .src_a     (src_a),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/pmul_8x16_tb_top.sv
module pmul_8x16_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;
  bit done    = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  pmul_8x16 dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [63:0] model(logic [2:0] o, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    bit wide = (o == 3'd5 || o == 3'd6);
    if (o == 3'd7) return '0;
    for (int i = 0; i < 4; i++) begin
      int x;
      int y;
      int p;
      logic [31:0] pu;
      if (!(wide && i >= 2)) begin
        case (o)
          3'd1:    y = int'($signed(b[31:16]));
          3'd2:    y = int'($signed(b[15:0]));
          default: y = int'($signed(b[16*i +: 16]));
        endcase
        case (o)
          3'd3, 3'd5: x = int'($signed(a[16*i+8 +: 8]));
          3'd4, 3'd6: x = int'(a[16*i +: 8]);
          default:    x = int'(a[8*i +: 8]);
        endcase
        p = x * y;
        if ((p & 255) > 127) p = p + 256;
        pu = p;
        if (wide) r[32*i +: 32] = pu;
        else      r[16*i +: 16] = pu[23:8];
      end
    end
    return r;
  endfunction

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] o, logic [63:0] a, logic [63:0] b,
                      logic [63:0] exp, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op       = o;
    src_a    = a;
    src_b    = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op       = 3'($urandom);
      src_a    = {$urandom, $urandom};
      src_b    = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [63:0] last;
    bit seen;
    seen = 1'b0;
    last = '0;
    forever begin
      @(posedge clk);
      #2;
      if (mon_en) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1: actual out_valid 1 expected 0 (no result pending)");
          end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(result, e, t);
            last = result;
            seen = 1'b1;
          end
        end else if (seen) begin
          check(result, last, "R2 hold while idle");
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op       = 3'd0;
    src_a    = 64'hFFFF_FFFF_FFFF_FFFF;
    src_b    = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    check({63'd0, out_valid}, 64'd0, "R2 reset out_valid");
    check(result, 64'd0, "R2 reset result");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    idle(2);
    check({63'd0, out_valid}, 64'd0, "R1 idle after reset");

    // R3: unsigned bytes of low half, unit multipliers
    send(3'd0, 64'h1234_5678_80FF_0201, 64'h0100_0100_0100_0100,
         64'h0080_00FF_0002_0001, "R3 per-lane bytes");
    // R4: rounding threshold 0x7F / 0x80, positive and negative
    send(3'd0, 64'h0000_0000_0101_0101, 64'hFF7F_FF80_0080_007F,
         64'hFFFF_0000_0001_0000, "R4 rounding boundary");
    send(3'd0, 64'hAAAA_AAAA_80FF_0201, 64'h1234_8000_7FFF_FFFF,
         model(3'd0, 64'hAAAA_AAAA_80FF_0201, 64'h1234_8000_7FFF_FFFF), "R4 extremes");
    idle(2);
    // R5 / R6: broadcast multiplier lanes
    send(3'd1, 64'h0000_0000_0202_0202, 64'h1111_2222_0400_0300,
         64'h0008_0008_0008_0008, "R5 broadcast lane 1");
    send(3'd2, 64'h0000_0000_0202_0202, 64'h1111_2222_0400_0300,
         64'h0006_0006_0006_0006, "R6 broadcast lane 0");
    // R7 / R8: signed high byte, unsigned low byte
    send(3'd3, 64'h01AA_FFBB_7FCC_80DD, 64'h0100_0100_0100_0100,
         64'h0001_FFFF_007F_FF80, "R7 signed high byte");
    send(3'd4, 64'h01AA_FFBB_7FCC_80DD, 64'h0100_0100_0100_0100,
         64'h00AA_00BB_00CC_00DD, "R8 unsigned low byte");
    // R9: wide forms
    send(3'd5, 64'h7777_7777_0255_FF33, 64'hDEAD_BEEF_0040_0100,
         64'h0000_0180_FFFF_FF00, "R9 wide signed high byte");
    send(3'd6, 64'h7777_7777_0281_FF33, 64'hDEAD_BEEF_FFFF_0100,
         model(3'd6, 64'h7777_7777_0281_FF33, 64'hDEAD_BEEF_FFFF_0100), "R9 wide unsigned low byte");
    // R10: reserved code
    send(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF,
         64'h0, "R10 reserved opcode");
    idle(3);

    // random mix, back-to-back and with gaps
    for (int n = 0; n < 300; n++) begin
      logic [2:0]  o;
      logic [63:0] a;
      logic [63:0] b;
      o = 3'($urandom);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      send(o, a, b, model(o, a, b), "R4 random mix");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    check(64'(exp_q.size()), 64'd0, "R1 every result delivered");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule